// File: doc/BRIEF.md
# Legacy Interrupt Routing Logic

This block collects interrupt requests from across the chip and its pins, and presents them to two consumers. The first is a 16-input legacy interrupt controller. The second is a 24-input I/O APIC. Request sources include:

- four active-low shared PCI interrupt pins;
- three plug-and-play request lines;
- the ACPI SCI;
- the decoded bits of the serial-IRQ frame;
- the ISA IRQ pins.

Software sets up the shared sources through 4-bit steering fields. Each legacy IRQ also has a trigger-mode bit, and that bit sets the polarity of the line the controller sees.

The fourth PCI pin is shared with an on-chip USB interrupt. The block drives that pad low through an open-drain output enable while the USB request is active. It reads the resolved pad level back as the fourth PCI source. Because of this, the USB request and any external device on the same wire merge as a wired-OR.

All asynchronous inputs pass through a two-flop synchronizer, and every output is registered. A change on a pin therefore reaches the outputs on the third rising clock edge that sees it. A change to the configuration reaches the outputs on the next edge.

Top module: `irq_router`

## Requirements
- R1: While `rst` is high at a clock edge, the next values of `pic_irq`, `apic_irq` and `pirqd_oe` are all zero, whatever the inputs are.
- R2: `pirqd_oe` is 1 after an edge at which `usb_irq` was 1, and 0 after an edge at which `usb_irq` was 0. A 1 drives the pad low; a 0 leaves it released.
- R3: The level read back on `pirq_pin_n[3]` is the fourth shared source. If the USB request alone pulls the pad low, the IRQ selected by that source's steering field is requested.
- R4: If bit n of `trig_level` is 1 (level mode), `pic_irq[n]` is 0 while IRQ n has a request and 1 while it has none.
- R5: If bit n of `trig_level` is 0 (edge mode), `pic_irq[n]` is 1 while IRQ n has a request and 0 while it has none.
- R6: Each shared source has a 4-bit field: bits [4j+3:4j] of `pirq_route` for PCI pin j, bits [4k+3:4k] of `pnp_route` for plug-and-play line k, and `sci_route` for the SCI. A value of 0 disconnects the source. A value v from 1 to 15 sends it to IRQ v. A PCI pin is active when low; the plug-and-play lines and the SCI are active when high.
- R7: The request for IRQ n is the OR of every active source that targets it. Each source is first converted to active-high, and the OR is then encoded per R4/R5.
- R8: ISA pin `isa_irq[n]` and serial-IRQ frame bit `serirq_bits[n]` (both active-high) each request IRQ n directly.
- R9: `apic_irq[n]` for n = 0 to 15 carries the synchronized `isa_irq[n]`. `apic_irq[16+j]` carries the synchronized, unconverted `pirq_pin_n[j]`. Bits 20 to 23 are 0.
- R10: A value on a request input at edge k shows at the outputs after edge k+2. The trigger-mode and steering inputs take effect at the next edge. Synchronizer stages leave reset at their inactive value (1 for PCI pins, 0 otherwise).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pirq_pin_n | input | 4 | Shared PCI interrupt pins, active low; bit 3 is the resolved USB-shared pad |
| pirqd_oe | output | 1 | Open-drain enable for the shared pad: 1 pulls it low |
| usb_irq | input | 1 | Internal USB interrupt request, active high |
| pnp_irq | input | 3 | Plug-and-play request lines, active high |
| sci_req | input | 1 | ACPI SCI request, active high |
| serirq_bits | input | 16 | Decoded serial-IRQ frame bits, active high |
| isa_irq | input | 16 | ISA IRQ pins, active high |
| trig_level | input | 16 | Per-IRQ trigger mode: 1 level (active low), 0 edge (active high) |
| pirq_route | input | 16 | Four 4-bit steering fields for the PCI pins |
| pnp_route | input | 12 | Three 4-bit steering fields for the plug-and-play lines |
| sci_route | input | 4 | Steering field for the SCI |
| pic_irq | output | 16 | Polarity-encoded lines to the legacy controller |
| apic_irq | output | 24 | Raw synchronized lines to the I/O APIC |

## Verification
The hardest condition to reach from the ports is the shared pad. The USB request, an external device, or both pull it low together, and the block samples its own open-drain drive one edge late through the synchronizer. The bench wires the pad as a wired-OR of `pirqd_oe` and a model of the external device. It then walks through each mix of the two sources while the fourth field steers to a fixed IRQ. A second hard case is several steered sources landing on one IRQ while its trigger mode flips. Directed phases cover that case, and a long random phase follows where all fields and pins change together.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned LEGACY_IRQS = 16;
  localparam int unsigned APIC_INPUTS = 24;
  localparam int unsigned PCI_LINES   = 4;
  localparam int unsigned PNP_LINES   = 3;
  localparam int unsigned ROUTE_W     = 4;
  localparam int unsigned SYNC_DEPTH  = 2;
  localparam int unsigned APIC_PCI_AT = 16;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] IDLE  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= IDLE;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |=> (q == $past(d, 2))); // R10
    end
  endgenerate
endmodule

// File: rtl/irq_steer.sv
module irq_steer #(
  parameter int unsigned N_LEG = 16,
  parameter int unsigned N_SRC = 8,
  parameter int unsigned SEL_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_SRC-1:0]       src_act,
  input  logic [N_SRC*SEL_W-1:0] src_sel,
  input  logic [N_LEG-1:0]       direct,
  output logic [N_LEG-1:0]       req
);
  logic [SEL_W-1:0] sel;

  always_comb begin
    req = direct;
    sel = '0;
    for (int s = 0; s < N_SRC; s++) begin
      sel = src_sel[s*SEL_W +: SEL_W];
      if (src_act[s] && (sel != '0) && (int'(sel) < int'(N_LEG))) req[sel] = 1'b1;
    end
  end

  generate
    for (genvar s = 0; s < N_SRC; s++) begin : g_chk
      AST_SOURCE_REACHES_IRQ: assert property (@(posedge clk) disable iff (rst)
        (src_act[s] && (src_sel[s*SEL_W +: SEL_W] != '0)
         && (int'(src_sel[s*SEL_W +: SEL_W]) < int'(N_LEG)))
        |-> req[src_sel[s*SEL_W +: SEL_W]]); // R7
    end
  endgenerate
endmodule

// File: rtl/irq_polarity.sv
module irq_polarity #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic [N-1:0] lvl_mode,
  output logic [N-1:0] line
);
  logic [N-1:0] line_q;

  always_ff @(posedge clk) begin
    if (rst) line_q <= '0;
    else     line_q <= req ^ lvl_mode;
  end

  assign line = line_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_chk
      AST_LEVEL_ACTIVE_LOW: assert property (@(posedge clk) disable iff (rst)
        (req[i] && lvl_mode[i]) |=> !line[i]); // R4
      AST_EDGE_ACTIVE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (req[i] && !lvl_mode[i]) |=> line[i]); // R5
    end
  endgenerate
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_pkg::*;
#(
  parameter int unsigned N_LEG     = LEGACY_IRQS,
  parameter int unsigned N_APIC    = APIC_INPUTS,
  parameter int unsigned N_PCI     = PCI_LINES,
  parameter int unsigned N_PNP     = PNP_LINES,
  parameter int unsigned SEL_W     = ROUTE_W,
  parameter int unsigned SYNC_STG  = SYNC_DEPTH,
  parameter int unsigned APIC_PCI0 = APIC_PCI_AT
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_PCI-1:0]       pirq_pin_n,
  output logic                   pirqd_oe,
  input  logic                   usb_irq,
  input  logic [N_PNP-1:0]       pnp_irq,
  input  logic                   sci_req,
  input  logic [N_LEG-1:0]       serirq_bits,
  input  logic [N_LEG-1:0]       isa_irq,
  input  logic [N_LEG-1:0]       trig_level,
  input  logic [N_PCI*SEL_W-1:0] pirq_route,
  input  logic [N_PNP*SEL_W-1:0] pnp_route,
  input  logic [SEL_W-1:0]       sci_route,
  output logic [N_LEG-1:0]       pic_irq,
  output logic [N_APIC-1:0]      apic_irq
);
  localparam int unsigned OFS_PNP = N_PCI;
  localparam int unsigned OFS_SCI = OFS_PNP + N_PNP;
  localparam int unsigned OFS_ISA = OFS_SCI + 1;
  localparam int unsigned OFS_SER = OFS_ISA + N_LEG;
  localparam int unsigned SYNC_W  = OFS_SER + N_LEG;
  localparam int unsigned N_SRC   = N_PCI + N_PNP + 1;
  localparam logic [SYNC_W-1:0] SYNC_IDLE = {{(SYNC_W-N_PCI){1'b0}}, {N_PCI{1'b1}}};

  logic [SYNC_W-1:0]      raw_bus, syn_bus;
  logic [N_PCI-1:0]       pirq_s;
  logic [N_PNP-1:0]       pnp_s;
  logic                   sci_s;
  logic [N_LEG-1:0]       isa_s, ser_s;
  logic [N_SRC-1:0]       src_act;
  logic [N_SRC*SEL_W-1:0] src_sel;
  logic [N_LEG-1:0]       irq_req;
  logic [N_APIC-1:0]      apic_next, apic_q;
  logic                   oe_q;

  assign raw_bus = {serirq_bits, isa_irq, sci_req, pnp_irq, pirq_pin_n};

  irq_sync #(.W(SYNC_W), .STAGES(SYNC_STG), .IDLE(SYNC_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(raw_bus), .q(syn_bus)
  );

  assign pirq_s = syn_bus[N_PCI-1:0];
  assign pnp_s  = syn_bus[OFS_PNP +: N_PNP];
  assign sci_s  = syn_bus[OFS_SCI];
  assign isa_s  = syn_bus[OFS_ISA +: N_LEG];
  assign ser_s  = syn_bus[OFS_SER +: N_LEG];

  // shared sources in active-high form with their steering fields
  assign src_act = {sci_s, pnp_s, ~pirq_s};
  assign src_sel = {sci_route, pnp_route, pirq_route};

  irq_steer #(.N_LEG(N_LEG), .N_SRC(N_SRC), .SEL_W(SEL_W)) u_steer (
    .clk(clk), .rst(rst), .src_act(src_act), .src_sel(src_sel),
    .direct(isa_s | ser_s), .req(irq_req)
  );

  irq_polarity #(.N(N_LEG)) u_pol (
    .clk(clk), .rst(rst), .req(irq_req), .lvl_mode(trig_level), .line(pic_irq)
  );

  always_comb begin
    apic_next = '0;
    apic_next[N_LEG-1:0] = isa_s;
    apic_next[APIC_PCI0 +: N_PCI] = pirq_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      apic_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      apic_q <= apic_next;
      oe_q   <= usb_irq;
    end
  end

  assign apic_irq = apic_q;
  assign pirqd_oe = oe_q;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> ((pic_irq == '0) && (apic_irq == '0) && !pirqd_oe)); // R1
  AST_PAD_DRIVE_ON: assert property (@(posedge clk) disable iff (rst)
    usb_irq |=> pirqd_oe); // R2
  AST_PAD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !usb_irq |=> !pirqd_oe); // R2
  AST_APIC_PCI_RAW: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |=> (apic_irq[APIC_PCI0 +: N_PCI] == $past(pirq_s))); // R9
  AST_APIC_ISA_RAW: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |=> (apic_irq[N_LEG-1:0] == $past(isa_s))); // R9
endmodule

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
module tb_irq_router;
  typedef struct packed {
    logic        rst;
    logic [3:0]  pin_n;
    logic [2:0]  pnp;
    logic        sci;
    logic [15:0] ser;
    logic [15:0] isa;
    logic        usb;
    logic [15:0] lvl;
    logic [15:0] proute;
    logic [11:0] nroute;
    logic [3:0]  sroute;
  } snap_t;

  logic clk = 1'b0;
  logic rst;
  logic [2:0] abc_n;
  logic ext_d;
  logic pad_n;
  logic pirqd_oe, usb_irq, sci_req;
  logic [2:0] pnp_irq;
  logic [15:0] serirq_bits, isa_irq, trig_level, pirq_route, pic_irq;
  logic [11:0] pnp_route;
  logic [3:0] sci_route;
  logic [23:0] apic_irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;
  string cur_req = "R1";
  snap_t hist[$];
  logic oe_seen = 1'b0;

  always #10 clk = ~clk;

  // wired-OR of the open-drain USB drive and an external device
  assign pad_n = ~(pirqd_oe | ext_d);

  irq_router dut (
    .clk(clk), .rst(rst), .pirq_pin_n({pad_n, abc_n}), .pirqd_oe(pirqd_oe),
    .usb_irq(usb_irq), .pnp_irq(pnp_irq), .sci_req(sci_req),
    .serirq_bits(serirq_bits), .isa_irq(isa_irq), .trig_level(trig_level),
    .pirq_route(pirq_route), .pnp_route(pnp_route), .sci_route(sci_route),
    .pic_irq(pic_irq), .apic_irq(apic_irq)
  );

  function automatic logic [15:0] want_req(snap_t p, snap_t c);
    logic [15:0] r;
    int v;
    r = p.isa | p.ser;
    for (int j = 0; j < 4; j++) begin
      v = int'(c.proute[4*j +: 4]);
      if (!p.pin_n[j] && v != 0) r[v] = 1'b1;
    end
    for (int k = 0; k < 3; k++) begin
      v = int'(c.nroute[4*k +: 4]);
      if (p.pnp[k] && v != 0) r[v] = 1'b1;
    end
    v = int'(c.sroute);
    if (p.sci && v != 0) r[v] = 1'b1;
    return r;
  endfunction

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h at cycle %0d", cur_req, what, act, exp, cycles);
    end
  endtask

  // reference model: snapshot of edge k, compare state after edge k
  always @(negedge clk) begin
    snap_t cur, src, idle;
    logic [15:0] e_pic;
    logic [23:0] e_apic;
    logic e_oe;
    int n;
    if (!done) begin
      cycles++;
      cur.rst = rst; cur.pin_n = {~(oe_seen | ext_d), abc_n}; cur.pnp = pnp_irq;
      cur.sci = sci_req; cur.ser = serirq_bits; cur.isa = isa_irq; cur.usb = usb_irq;
      cur.lvl = trig_level; cur.proute = pirq_route; cur.nroute = pnp_route;
      cur.sroute = sci_route;
      hist.push_back(cur);
      if (hist.size() > 3) void'(hist.pop_front());
      n = hist.size();
      idle = '0; idle.pin_n = 4'hF;
      if (cur.rst) begin
        e_pic = '0; e_apic = '0; e_oe = 1'b0;
      end else begin
        if (n < 3 || hist[n-3].rst || hist[n-2].rst) src = idle;
        else src = hist[n-3];
        e_pic  = want_req(src, cur) ^ cur.lvl;
        e_apic = {4'b0000, src.pin_n, src.isa};
        e_oe   = cur.usb;
      end
      cmp("pic_irq", {16'h0, pic_irq}, {16'h0, e_pic});
      cmp("apic_irq", {8'h0, apic_irq}, {8'h0, e_apic});
      cmp("pirqd_oe", {31'h0, pirqd_oe}, {31'h0, e_oe});
      oe_seen = pirqd_oe;
      if (cycles > 50000) begin
        bad++;
        $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        done = 1;
        $finish;
      end
    end
  end

  task automatic tick(int n);
    repeat (n) begin
      @(negedge clk);
      #5;
    end
  endtask

  initial begin
    rst = 1'b1; abc_n = 3'b111; ext_d = 1'b0; usb_irq = 1'b0; pnp_irq = '0;
    sci_req = 1'b0; serirq_bits = '1; isa_irq = '1; trig_level = '0;
    pirq_route = '0; pnp_route = '0; sci_route = '0;
    // R1: active inputs held during reset
    cur_req = "R1"; usb_irq = 1'b1; abc_n = 3'b000; tick(5);
    isa_irq = '0; serirq_bits = '0; usb_irq = 1'b0; abc_n = 3'b111; rst = 1'b0;
    cur_req = "R10"; tick(4);
    // R5: edge mode, walking ISA request
    cur_req = "R5";
    for (int i = 0; i < 16; i++) begin isa_irq = 16'h1 << i; tick(4); end
    isa_irq = '0; tick(4);
    // R4: level mode
    cur_req = "R4"; trig_level = '1; tick(3);
    for (int i = 0; i < 16; i++) begin isa_irq = 16'h1 << i; tick(4); end
    isa_irq = '0; tick(4);
    // R8: serial-IRQ frame bits, mixed modes
    cur_req = "R8"; trig_level = 16'h00FF;
    for (int i = 0; i < 16; i++) begin serirq_bits = 16'h1 << i; tick(4); end
    serirq_bits = '0; tick(4);
    // R6: steering and disable
    cur_req = "R6"; pirq_route = 16'h0005; abc_n = 3'b110; tick(5);
    pirq_route = 16'h0000; tick(5);
    pirq_route = 16'h0070; abc_n = 3'b101; tick(5); abc_n = 3'b111; tick(4);
    pnp_route = 12'hF0C; pnp_irq = 3'b101; tick(5); pnp_irq = 3'b000; tick(4);
    sci_route = 4'd9; sci_req = 1'b1; tick(5); sci_route = 4'd0; tick(3); sci_req = 1'b0; tick(4);
    // R7: several sources on one IRQ
    cur_req = "R7"; pirq_route = 16'h000A; pnp_route = 12'h0A0; trig_level = 16'h0400;
    abc_n = 3'b110; tick(4); pnp_irq = 3'b010; tick(4); abc_n = 3'b111; tick(4);
    isa_irq = 16'h0400; tick(4); pnp_irq = 3'b000; tick(4); isa_irq = '0; tick(4);
    // R2/R3: shared pad with USB and external device
    cur_req = "R3"; pirq_route = 16'hB000; trig_level = 16'h0800;
    usb_irq = 1'b1; tick(6); usb_irq = 1'b0; tick(5);
    cur_req = "R2"; ext_d = 1'b1; tick(5); usb_irq = 1'b1; tick(4); ext_d = 1'b0; tick(4);
    usb_irq = 1'b0; tick(5);
    for (int i = 0; i < 12; i++) begin usb_irq = ~usb_irq; tick(1); end
    usb_irq = 1'b0; tick(4);
    // R10: config changes each edge while a request is held
    cur_req = "R10"; isa_irq = 16'h0040;
    for (int i = 0; i < 10; i++) begin trig_level = trig_level ^ 16'h0040; tick(1); end
    isa_irq = '0; tick(4);
    // R9 and R7: random mix of everything
    cur_req = "R9";
    for (int i = 0; i < 400; i++) begin
      abc_n = 3'($urandom); ext_d = 1'($urandom); usb_irq = 1'($urandom);
      pnp_irq = 3'($urandom); sci_req = 1'($urandom);
      serirq_bits = 16'($urandom) & 16'($urandom) & 16'($urandom);
      isa_irq = 16'($urandom) & 16'($urandom) & 16'($urandom);
      if (i % 7 == 0) begin
        trig_level = 16'($urandom); pirq_route = 16'($urandom);
        pnp_route = 12'($urandom); sci_route = 4'($urandom);
      end
      if (i == 200) rst = 1'b1;
      if (i == 203) rst = 1'b0;
      tick(1 + (i % 3));
    end
    tick(4);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule